// File: doc/BRIEF.md
# Fractional Dual-Modulus Feedback Divider

This block sits in the feedback path of a frequency synthesizer loop. It divides a fast input clock by an integer ratio for each output period. The ratio is either N or N+1. The choice of modulus is made per output period by a fractional accumulator. The accumulator adds a fraction word once per output period. When the addition carries out, the next period uses N+1. If the fraction word is f and the accumulator has F bits, exactly f periods out of every 2^F use the longer modulus. The long-run division ratio is therefore N + f/2^F, and the loop settles at the reference frequency times that ratio.

The block has two control words, an integer ratio and a fraction. They are sampled only at the edge that closes a period, so a change never shortens or stretches a period already in progress. Integer ratios below two are raised to two. The outputs are two signals. The first is a one-clock pulse at the terminal count of each period. The second is a flag that stays high for the whole of any period counted at N+1.

Top module: `fracn_div`

## Requirements
- R1: `div_pulse` is high for exactly one clock, in the last clock of each output period. Every period lasts N or N+1 input clocks. With an N_W-bit ratio port, the longest period is 2^N_W clocks.
- R2: `mod_hi` is 1 for the whole of a period that lasts N+1 clocks and 0 for the whole of a period that lasts N clocks.
- R3: With constant control words, any 2^F_W consecutive periods contain exactly f periods at N+1. Their total length is 2^F_W·N + f clocks.
- R4: A ratio word of 0 or 1 acts as a ratio of 2.
- R5: The ratio and fraction words are sampled only at the clock edge where `div_pulse` is high. A change at any other time leaves the current period's length and `mod_hi` unchanged, and it applies from the next period onward.
- R6: While `rst` is high, `div_pulse` and `mod_hi` are 0 and the accumulator is cleared. The first period after release uses the ratio word present during reset. Its pulse appears N−1 clocks after release, because the release clock counts as the first clock of that period.
- R7: `div_pulse` is never high in two consecutive clocks.
- R8: A fraction word of 0 gives plain integer division, and `mod_hi` stays 0.
- R9: At each period-closing edge, the accumulator adds the fraction word and keeps the low F_W bits. The carry out of that addition becomes `mod_hi` for the period that starts there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| n_in | input | N_W | Integer ratio N, clamped to at least 2 |
| frac_in | input | F_W | Fraction word f; the average ratio is N + f/2^F_W |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| mod_hi | output | 1 | High while the current period is counted at N+1 |

## Verification
On every cycle, the assertions check the following: the pulse is one clock wide, no period is shorter than two or longer than 2^N_W clocks, the modulus flag changes only at a period boundary, a zero fraction never raises the flag, the latched ratio never falls below two, and the state after reset is correct. Some properties can only be shown by the bench's scenarios. One is the exact length of each period against a model that samples the control words at the boundary. Another is that mid-period changes apply at the next boundary. The last is the long-run count of N+1 periods over a full accumulator wrap, which must match the fraction word.

// File: rtl/fracn_div_pkg.sv
`timescale 1ns/1ps
package fracn_div_pkg;
   // Implementation choice for the period counter.
   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_style_e;

   // Smallest ratio the counter can realise while keeping the pulse one clock wide.
   localparam int unsigned MIN_RATIO = 2;
endpackage

// File: rtl/fracn_div_ratio.sv
`timescale 1ns/1ps
module fracn_div_ratio #(
   parameter int N_W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [N_W-1:0] n_req,
   output logic [N_W-1:0] n_lim,
   output logic [N_W-1:0] n_act
);
   localparam logic [N_W-1:0] FLOOR = N_W'(fracn_div_pkg::MIN_RATIO);

   // Raise ratios that are too small to the floor.
   assign n_lim = (n_req < FLOOR) ? FLOOR : n_req;

   // The ratio is held for a whole period. It is reloaded only at a boundary or in reset.
   always_ff @(posedge clk) begin
      if (rst || load) n_act <= n_lim;
   end

   // R4: the ratio in use never drops below the floor.
   p_floor_r4: assert property (@(posedge clk) disable iff (rst)
      n_act >= FLOOR);
endmodule

// File: rtl/fracn_div_acc.sv
`timescale 1ns/1ps
module fracn_div_acc #(
   parameter int F_W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           step,
   input  logic [F_W-1:0] frac,
   output logic           carry_nxt,
   output logic           mod_hi
);
   logic [F_W-1:0] acc_q;
   logic [F_W:0]   sum;

   assign sum       = {1'b0, acc_q} + {1'b0, frac};
   assign carry_nxt = sum[F_W];

   // One accumulation per output period. The carry selects the long modulus.
   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         mod_hi <= 1'b0;
      end else if (step) begin
         acc_q  <= sum[F_W-1:0];
         mod_hi <= sum[F_W];
      end
   end

   // R8: a zero fraction can never select the long modulus.
   p_zero_frac_r8: assert property (@(posedge clk) disable iff (rst)
      (step && frac == '0) |=> !mod_hi);
endmodule

// File: rtl/fracn_div_cnt.sv
`timescale 1ns/1ps
module fracn_div_cnt #(
   parameter int                         N_W   = 8,
   parameter fracn_div_pkg::cnt_style_e STYLE = fracn_div_pkg::CNT_DOWN
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N_W:0] cur_len,
   input  logic [N_W:0] nxt_len,
   input  logic [N_W:0] rst_len,
   output logic         term
);
   localparam logic [N_W:0] ONE = (N_W+1)'(1);

   generate
      if (STYLE == fracn_div_pkg::CNT_UP) begin : g_up
         // Count up from zero. Compare against the length of the period in progress.
         logic [N_W-1:0] cnt_q;
         logic [N_W:0]   last;
         assign last = cur_len - ONE;
         assign term = ({1'b0, cnt_q} == last);
         always_ff @(posedge clk) begin
            if (rst)       cnt_q <= '0;
            else if (term) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_down
         // Count down to zero. Preload the length of the next period at the boundary.
         logic [N_W-1:0] rem_q;
         logic [N_W:0]   rst_m1;
         logic [N_W:0]   nxt_m1;
         assign rst_m1 = rst_len - ONE;
         assign nxt_m1 = nxt_len - ONE;
         assign term   = (rem_q == '0);
         always_ff @(posedge clk) begin
            if (rst)       rem_q <= rst_m1[N_W-1:0];
            else if (term) rem_q <= nxt_m1[N_W-1:0];
            else           rem_q <= rem_q - 1'b1;
         end
      end
   endgenerate

   // R7: a terminal count is always followed by a non-terminal clock.
   p_term_gap_r7: assert property (@(posedge clk) disable iff (rst)
      term |=> !term);
endmodule

// File: rtl/fracn_div.sv
`timescale 1ns/1ps
module fracn_div #(
   parameter int                         N_W       = 8,
   parameter int                         F_W       = 8,
   parameter fracn_div_pkg::cnt_style_e CNT_STYLE = fracn_div_pkg::CNT_DOWN
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N_W-1:0] n_in,
   input  logic [F_W-1:0] frac_in,
   output logic           div_pulse,
   output logic           mod_hi
);
   localparam int L_W = N_W + 1;

   // Parameter legality checks at elaboration.
   if (N_W < 2 || N_W > 30) begin : g_bad_nw
      $error("fracn_div: N_W must lie in 2..30");
   end
   if (F_W < 1 || F_W > 30) begin : g_bad_fw
      $error("fracn_div: F_W must lie in 1..30");
   end

   logic [N_W-1:0] n_lim;
   logic [N_W-1:0] n_act;
   logic           carry_nxt;
   logic           term;
   logic [L_W-1:0] cur_len;
   logic [L_W-1:0] nxt_len;
   logic [L_W-1:0] rst_len;

   fracn_div_ratio #(.N_W(N_W)) ratio_i (
      .clk   (clk),
      .rst   (rst),
      .load  (term),
      .n_req (n_in),
      .n_lim (n_lim),
      .n_act (n_act)
   );

   fracn_div_acc #(.F_W(F_W)) acc_i (
      .clk       (clk),
      .rst       (rst),
      .step      (term),
      .frac      (frac_in),
      .carry_nxt (carry_nxt),
      .mod_hi    (mod_hi)
   );

   assign cur_len = {1'b0, n_act} + L_W'(mod_hi);
   assign nxt_len = {1'b0, n_lim} + L_W'(carry_nxt);
   assign rst_len = {1'b0, n_lim};

   fracn_div_cnt #(.N_W(N_W), .STYLE(CNT_STYLE)) cnt_i (
      .clk     (clk),
      .rst     (rst),
      .cur_len (cur_len),
      .nxt_len (nxt_len),
      .rst_len (rst_len),
      .term    (term)
   );

   assign div_pulse = term;

   // Checker state: clocks elapsed since the last pulse or since reset.
   localparam logic [L_W:0] GAP_MAX = (L_W+1)'((1 << N_W) - 1);
   logic [L_W:0] gap_q;
   always_ff @(posedge clk) begin
      if (rst || div_pulse) gap_q <= '0;
      else                  gap_q <= gap_q + 1'b1;
   end

   // R4: no period is shorter than two clocks.
   p_gap_floor_r4: assert property (@(posedge clk) disable iff (rst)
      div_pulse |-> (gap_q >= (L_W+1)'(1)));

   // R1: no period is longer than 2^N_W clocks.
   p_gap_ceil_r1: assert property (@(posedge clk) disable iff (rst)
      gap_q <= GAP_MAX);

   // R5: the modulus flag changes only at a period boundary.
   p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !div_pulse |=> $stable(mod_hi));

   // R6: reset leaves no pulse and the short modulus selected.
   p_reset_state_r6: assert property (@(posedge clk)
      rst |=> (!div_pulse && !mod_hi));
endmodule

// File: tb/fracn_div_tb_top.sv
`timescale 1ns/1ps
module fracn_div_tb_top;
   localparam int N_W = 8;
   localparam int F_W = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [N_W-1:0] n_in = '0;
   logic [F_W-1:0] frac_in = '0;
   logic           div_pulse;
   logic           mod_hi;

   int vectors = 0;
   int errs    = 0;
   bit done    = 0;

   // Requirement-level model state.
   int m_cnt, m_len, m_acc, m_plus;

   always #5 clk = ~clk;

   fracn_div #(.N_W(N_W), .F_W(F_W)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .n_in      (n_in),
      .frac_in   (frac_in),
      .div_pulse (div_pulse),
      .mod_hi    (mod_hi)
   );

   function automatic int clampn(int n);
      return (n < 2) ? 2 : n;
   endfunction

   task automatic chk(string req, int act, int exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Drive the inputs and let one clock edge pass. Advance the model, then check at the falling edge.
   task automatic step(int nn, int ff);
      n_in    = N_W'(nn);
      frac_in = F_W'(ff);
      @(posedge clk);
      if (m_cnt == m_len - 1) begin
         int s;
         s      = m_acc + ff;
         m_acc  = s % (1 << F_W);
         m_plus = s >> F_W;
         m_len  = clampn(nn) + m_plus;
         m_cnt  = 0;
      end else begin
         m_cnt++;
      end
      @(negedge clk);
      chk("R1 pulse position", int'(div_pulse), int'(m_cnt == m_len - 1));
      chk("R2 R9 modulus flag", int'(mod_hi), m_plus);
   endtask

   task automatic do_reset(int nn, int ff);
      @(negedge clk);
      rst     = 1'b1;
      n_in    = N_W'(nn);
      frac_in = F_W'(ff);
      repeat (3) begin
         @(negedge clk);
         chk("R6 pulse in reset", int'(div_pulse), 0);
         chk("R6 flag in reset", int'(mod_hi), 0);
      end
      rst    = 1'b0;
      m_cnt  = 0;
      m_acc  = 0;
      m_plus = 0;
      m_len  = clampn(nn);
   endtask

   task automatic run_to_pulse(int nn, int ff, output int k);
      k = 0;
      do begin
         step(nn, ff);
         k++;
      end while (div_pulse !== 1'b1 && k < 1000);
   endtask

   initial begin
      int k, total, hi;
      bit prev;
      int nn, ff;
      void'($urandom(32'd7741));

      // R6 and R8: reset, then plain integer division.
      do_reset(5, 0);
      run_to_pulse(5, 0, k);
      chk("R6 first period after release", k, 4);
      for (int i = 0; i < 20; i++) begin
         run_to_pulse(5, 0, k);
         chk("R8 integer period", k, 5);
         chk("R8 flag low", int'(mod_hi), 0);
      end

      // R5: a ratio change in the middle of a period is deferred to the next boundary.
      run_to_pulse(4, 0, k);
      chk("R5 new ratio at boundary", k, 4);
      step(4, 0);
      run_to_pulse(9, 0, k);
      chk("R5 current period unchanged", k + 1, 4);
      run_to_pulse(9, 0, k);
      chk("R5 next period uses new ratio", k, 9);

      // R4: ratios of 0 and 1 act as 2.
      do_reset(1, 0);
      run_to_pulse(1, 0, k);
      chk("R4 first period ratio 1", k, 1);
      run_to_pulse(0, 0, k);
      chk("R4 ratio 0 clamped", k, 2);
      run_to_pulse(1, 0, k);
      chk("R4 ratio 1 clamped", k, 2);

      // R3: over one full accumulator wrap.
      do_reset(3, 77);
      run_to_pulse(3, 77, k);
      total = 0; hi = 0;
      for (int i = 0; i < 256; i++) begin
         run_to_pulse(3, 77, k);
         chk("R2 length matches flag", k, 3 + int'(mod_hi));
         total += k;
         hi    += int'(mod_hi);
      end
      chk("R3 long periods per wrap", hi, 77);
      chk("R3 total clocks per wrap", total, 256 * 3 + 77);

      do_reset(7, 1);
      run_to_pulse(7, 1, k);
      total = 0;
      for (int i = 0; i < 256; i++) begin
         run_to_pulse(7, 1, k);
         total += k;
      end
      chk("R3 total clocks small fraction", total, 256 * 7 + 1);

      // R1: the largest ratio with carries.
      do_reset(255, 255);
      run_to_pulse(255, 255, k);
      chk("R1 first max period", k, 254);
      run_to_pulse(255, 255, k);
      chk("R1 max ratio no carry", k, 255);
      run_to_pulse(255, 255, k);
      chk("R1 max ratio with carry", k, 256);

      // Random words that change at arbitrary clocks, including mid-period.
      do_reset(6, 100);
      nn = 6; ff = 100; prev = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 9 == 0) begin
            nn = int'($urandom % 14);
            ff = int'($urandom % 256);
         end
         step(nn, ff);
         if (prev) chk("R7 no back-to-back pulse", int'(div_pulse), 0);
         prev = div_pulse;
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end
endmodule